// File: doc/BRIEF.md
# Overcurrent Hiccup Fault Controller

This block sits beside the switch sequencer of a synchronous step-down regulator. It decides when repeated high-side current-limit events justify a full stop of the converter. Each limit event that the sequencer reports is counted. A run of clean high-side cycles forgives the accumulated count. When the count fills up, the block enters hiccup: both power switches are held off, the soft-start node is discharged, and the controller waits a fixed number of switching periods before it releases the converter into a fresh soft-start.

An over-temperature input follows the same inhibit-then-restart pattern, and it takes precedence over everything else. When `enable` is low the counters are kept empty and no restart is requested. A hiccup that is already running still finishes its wait, so the switches are not released early. All pins are plain control levels or single-cycle strobes from the sequencer. There is no data path and no handshake.

A switching period opens with a `cycle_start` strobe. A `hs_turned_on` strobe or an `hs_ilim_hit` strobe in the same clock as `cycle_start` belongs to the period that is opening.

Top module: `hiccup_fault_ctrl`

## Requirements
- R1: While and right after reset, `inhibit`, `ss_discharge` and `restart_softstart` are all low.
- R2: In the running state with `enable` high, every clock with `hs_ilim_hit` high counts one event. The eighth event that arrives with no clearing in between drives `inhibit` and `ss_discharge` high from the next clock onward.
- R3: A period is clean when `hs_turned_on` was seen in it and `hs_ilim_hit` was not. Periods are judged when the next `cycle_start` arrives. Three clean periods in a row reset the event count to zero.
- R4: A current-limit event restarts the clean-period streak from zero. Two clean periods, then a limit event, then two clean periods do not clear the count.
- R5: Hiccup ends on the clock edge that samples the 1024th `cycle_start` after entry. From the next clock, `inhibit` and `ss_discharge` are low and `restart_softstart` is high for exactly one clock.
- R6: Current-limit events seen during hiccup are not counted. After hiccup ends, it takes eight new events to re-enter hiccup.
- R7: While `thermal_fault` is high, `inhibit` and `ss_discharge` are high from the next clock, even if a hiccup was running. The event count is emptied. On the first clock with `thermal_fault` low, both return low on the next clock and `restart_softstart` pulses once.
- R8: `restart_softstart` pulses only if `enable` is high on the clock edge where the hiccup ends or the thermal fault clears. Otherwise the inhibit is still released, but no pulse is issued.
- R9: While `enable` is low, limit events are ignored and the event count and streak are emptied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_start | input | 1 | One-clock strobe opening each switching period |
| hs_turned_on | input | 1 | Strobe: high-side switch was turned on in this period |
| hs_ilim_hit | input | 1 | Strobe: high-side current limit tripped |
| thermal_fault | input | 1 | Over-temperature level from the die sensor |
| enable | input | 1 | Regulator enable level |
| inhibit | output | 1 | Hold both power switches off |
| ss_discharge | output | 1 | Request discharge of the soft-start node |
| restart_softstart | output | 1 | One-clock request to begin a new soft-start |

## Verification
The bench builds the controller with its default parameters: an eight-event limit, a three-period forgiveness run and a 1024-period wait. Each switching period lasts four clocks. With these values a full hiccup takes about four thousand clocks, so the run can afford several complete waits. That lets it observe the exact release period, hits that are ignored during a wait, and a release with `enable` low or with a thermal fault in the middle of a wait. The random phase mixes hit, clean and idle periods with toggles of `enable` and of the thermal fault, and compares every clock against a reference model.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

  typedef enum logic [1:0] {
    HC_RUN     = 2'd0,
    HC_WAIT    = 2'd1,
    HC_THERMAL = 2'd2
  } hc_state_e;

endpackage

// File: rtl/ilim_event_tracker.sv
module ilim_event_tracker #(
  parameter int EVENT_LIMIT = 8,
  parameter int CLEAN_RUN   = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic cycle_start,
  input  logic hs_turned_on,
  input  logic hs_ilim_hit,
  output logic trip
);

  localparam int EV_W = (EVENT_LIMIT > 1) ? $clog2(EVENT_LIMIT) : 1;
  localparam int ST_W = $clog2(CLEAN_RUN + 1);
  localparam logic [EV_W-1:0] EV_LAST = EV_W'(EVENT_LIMIT - 1);
  localparam logic [ST_W-1:0] ST_LAST = ST_W'(CLEAN_RUN - 1);

  logic [EV_W-1:0] ev_cnt;
  logic [ST_W-1:0] streak;
  logic            on_seen;
  logic            hit_seen;
  logic            clean_close;

  // a period closes clean when the high side fired without tripping the limit
  assign clean_close = cycle_start & on_seen & ~hit_seen;
  assign trip        = hs_ilim_hit & ~clear & (ev_cnt == EV_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_seen  <= 1'b0;
      hit_seen <= 1'b0;
    end else if (clear) begin
      on_seen  <= 1'b0;
      hit_seen <= 1'b0;
    end else if (cycle_start) begin
      on_seen  <= hs_turned_on;
      hit_seen <= hs_ilim_hit;
    end else begin
      on_seen  <= on_seen | hs_turned_on;
      hit_seen <= hit_seen | hs_ilim_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_cnt <= '0;
      streak <= '0;
    end else if (clear) begin
      ev_cnt <= '0;
      streak <= '0;
    end else if (hs_ilim_hit) begin
      streak <= '0;
      if (ev_cnt != EV_LAST) ev_cnt <= ev_cnt + 1'b1;
    end else if (clean_close) begin
      if (streak == ST_LAST) begin
        ev_cnt <= '0;
        streak <= '0;
      end else begin
        streak <= streak + 1'b1;
      end
    end
  end

endmodule

// File: rtl/hiccup_timer.sv
module hiccup_timer #(
  parameter int HICCUP_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic cycle_start,
  output logic done
);

  localparam int TM_W = (HICCUP_CYCLES > 1) ? $clog2(HICCUP_CYCLES) : 1;
  localparam logic [TM_W-1:0] TM_LAST = TM_W'(HICCUP_CYCLES - 1);

  logic [TM_W-1:0] periods;

  assign done = run & cycle_start & (periods == TM_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 periods <= '0;
    else if (!run || done)      periods <= '0;
    else if (cycle_start)       periods <= periods + 1'b1;
  end

endmodule

// File: rtl/hiccup_fault_ctrl.sv
module hiccup_fault_ctrl
  import hiccup_pkg::*;
#(
  parameter int EVENT_LIMIT   = 8,
  parameter int CLEAN_RUN     = 3,
  parameter int HICCUP_CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_start,
  input  logic hs_turned_on,
  input  logic hs_ilim_hit,
  input  logic thermal_fault,
  input  logic enable,
  output logic inhibit,
  output logic ss_discharge,
  output logic restart_softstart
);

  hc_state_e state_q, state_d;
  logic      restart_d;
  logic      trk_clear;
  logic      trip_w;
  logic      wait_done;

  assign trk_clear = (state_q != HC_RUN) | ~enable | thermal_fault;

  ilim_event_tracker #(
    .EVENT_LIMIT(EVENT_LIMIT),
    .CLEAN_RUN  (CLEAN_RUN)
  ) u_trk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (trk_clear),
    .cycle_start (cycle_start),
    .hs_turned_on(hs_turned_on),
    .hs_ilim_hit (hs_ilim_hit),
    .trip        (trip_w)
  );

  hiccup_timer #(
    .HICCUP_CYCLES(HICCUP_CYCLES)
  ) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (state_q == HC_WAIT),
    .cycle_start(cycle_start),
    .done       (wait_done)
  );

  always_comb begin
    state_d   = state_q;
    restart_d = 1'b0;
    if (thermal_fault) begin
      state_d = HC_THERMAL;
    end else begin
      unique case (state_q)
        HC_RUN:     if (trip_w) state_d = HC_WAIT;
        HC_WAIT:    if (wait_done) begin
                      state_d   = HC_RUN;
                      restart_d = enable;
                    end
        HC_THERMAL: begin
                      state_d   = HC_RUN;
                      restart_d = enable;
                    end
        default:    state_d = HC_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q           <= HC_RUN;
      restart_softstart <= 1'b0;
    end else begin
      state_q           <= state_d;
      restart_softstart <= restart_d;
    end
  end

  assign inhibit      = (state_q != HC_RUN);
  assign ss_discharge = (state_q != HC_RUN);

endmodule

// File: rtl/hiccup_fault_ctrl_checker.sv
module hiccup_fault_ctrl_checker (
  input logic clk,
  input logic rst_n,
  input logic thermal_fault,
  input logic enable,
  input logic trip_w,
  input logic inhibit,
  input logic ss_discharge,
  input logic restart_softstart
);

  a_r2_trip_stops_switches: assert property (@(posedge clk) disable iff (!rst_n)
    trip_w && !thermal_fault |=> inhibit && ss_discharge);

  a_r7_thermal_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
    thermal_fault |=> inhibit && ss_discharge);

  a_r8_restart_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restart_softstart) |-> $past(enable));

  a_r5_restart_single: assert property (@(posedge clk) disable iff (!rst_n)
    restart_softstart |=> !restart_softstart);

  a_r5_restart_on_release: assert property (@(posedge clk) disable iff (!rst_n)
    restart_softstart |-> !inhibit && $past(inhibit));

endmodule

bind hiccup_fault_ctrl hiccup_fault_ctrl_checker u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .thermal_fault    (thermal_fault),
  .enable           (enable),
  .trip_w           (trip_w),
  .inhibit          (inhibit),
  .ss_discharge     (ss_discharge),
  .restart_softstart(restart_softstart)
);

// File: tb/hiccup_fault_ctrl_test.sv
module hiccup_fault_ctrl_test;

  localparam int EL = 8;
  localparam int CR = 3;
  localparam int HC = 1024;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, on = 1'b0, hit = 1'b0, therm = 1'b0, en = 1'b1;
  logic inh, ssd, rss;

  int checks = 0, fails = 0, rs_cnt = 0, cyc = 0;

  // reference model state
  int m_state = 0, m_ev = 0, m_st = 0, m_tmr = 0;
  bit m_on = 0, m_hit = 0, m_rs = 0, m_close = 0;

  always #5 clk = ~clk;

  hiccup_fault_ctrl #(.EVENT_LIMIT(EL), .CLEAN_RUN(CR), .HICCUP_CYCLES(HC)) uut (
    .clk(clk), .rst_n(rst_n), .cycle_start(cs), .hs_turned_on(on),
    .hs_ilim_hit(hit), .thermal_fault(therm), .enable(en),
    .inhibit(inh), .ss_discharge(ssd), .restart_softstart(rss)
  );

  function automatic bit next_flag(bit cur, bit open, bit ev);
    return open ? ev : (cur | ev);
  endfunction

  task automatic m_clear();
    m_ev = 0; m_st = 0; m_on = 0; m_hit = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_tmr = 0; m_rs = 0; m_clear();
    end else begin
      m_rs = 0;
      if (therm) begin
        m_state = 2; m_tmr = 0; m_clear();
      end else if (m_state == 2) begin
        m_state = 0; m_rs = en; m_clear();
      end else if (m_state == 1) begin
        m_clear();
        if (cs) begin
          if (m_tmr == HC - 1) begin m_state = 0; m_rs = en; m_tmr = 0; end
          else m_tmr++;
        end
      end else if (!en) begin
        m_clear();
      end else begin
        m_close = cs && m_on && !m_hit;
        m_on  = next_flag(m_on, cs, on);
        m_hit = next_flag(m_hit, cs, hit);
        if (hit) begin
          if (m_ev == EL - 1) begin m_state = 1; m_tmr = 0; m_clear(); end
          else begin m_ev++; m_st = 0; end
        end else if (m_close) begin
          if (m_st == CR - 1) begin m_ev = 0; m_st = 0; end
          else m_st++;
        end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic step(input logic c, input logic o, input logic h);
    cs = c; on = o; hit = h;
    @(posedge clk);
    @(negedge clk);
    if (rss) rs_cnt++;
    check("R2/R5/R7 inhibit vs model", int'(inh), int'(m_state != 0));
    check("R2/R7 ss_discharge vs model", int'(ssd), int'(m_state != 0));
    check("R5/R8 restart vs model", int'(rss), int'(m_rs));
  endtask

  // kind: 0 idle, 1 clean, 2 limit hit
  task automatic period(input int kind);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, kind != 0, 1'b0);
    step(1'b0, 1'b0, kind == 2);
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic periods(input int kind, input int n);
    for (int i = 0; i < n; i++) period(kind);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  initial begin
    int rs0;
    void'($urandom(32'd7321));
    repeat (3) @(negedge clk);
    check("R1 inhibit in reset", int'(inh), 0);
    check("R1 ss_discharge in reset", int'(ssd), 0);
    check("R1 restart in reset", int'(rss), 0);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0);
    check("R1 inhibit after reset", int'(inh), 0);

    // R2: seven events stay running, the eighth trips
    periods(2, EL - 1);
    check("R2 seven events no trip", int'(inh), 0);
    period(2);
    check("R2 eighth event inhibit", int'(inh), 1);
    check("R2 eighth event discharge", int'(ssd), 1);

    // R5 and R6: wait length, hits ignored during it
    periods(2, HC - 1);
    check("R5 still waiting after 1023", int'(inh), 1);
    rs0 = rs_cnt;
    period(0);
    check("R5 released after 1024", int'(inh), 0);
    check("R5 one restart pulse", rs_cnt - rs0, 1);
    periods(2, EL - 1);
    check("R6 wait hits not counted", int'(inh), 0);

    // R3: three clean periods forgive the count
    periods(1, CR);
    periods(2, EL - 1);
    check("R3 count cleared by clean run", int'(inh), 0);
    period(2);
    check("R3 eighth after clear trips", int'(inh), 1);
    periods(0, HC);
    check("R5 released again", int'(inh), 0);

    // R4: a hit breaks the streak
    periods(2, EL - 2);
    periods(1, 2);
    period(2);
    periods(1, 2);
    period(2);
    check("R4 broken streak keeps count", int'(inh), 1);

    // R8: release with enable low gives no pulse
    en = 1'b0;
    rs0 = rs_cnt;
    periods(0, HC);
    check("R8 released with enable low", int'(inh), 0);
    check("R8 no restart pulse", rs_cnt - rs0, 0);

    // R9: enable low empties the count and ignores hits
    periods(2, EL + 2);
    check("R9 hits ignored when disabled", int'(inh), 0);
    en = 1'b1;
    periods(2, 5);
    en = 1'b0;
    period(0);
    en = 1'b1;
    periods(2, EL - 1);
    check("R9 count emptied by disable", int'(inh), 0);
    periods(1, CR + 1);

    // R7: thermal fault in running state
    periods(2, 4);
    therm = 1'b1;
    periods(1, 2);
    check("R7 thermal inhibit", int'(inh), 1);
    check("R7 thermal discharge", int'(ssd), 1);
    therm = 1'b0;
    rs0 = rs_cnt;
    period(0);
    check("R7 released after thermal", int'(inh), 0);
    check("R7 restart after thermal", rs_cnt - rs0, 1);
    periods(2, EL - 1);
    check("R7 thermal emptied count", int'(inh), 0);
    periods(1, CR + 1);

    // R7: thermal fault overrides a running wait
    periods(2, EL);
    periods(0, 10);
    therm = 1'b1;
    period(0);
    therm = 1'b0;
    rs0 = rs_cnt;
    period(0);
    check("R7 thermal ends wait early", int'(inh), 0);
    check("R7 restart after wait abort", rs_cnt - rs0, 1);

    // random mix checked against the model each clock
    for (int i = 0; i < 1200; i++) begin
      int r;
      r = int'($urandom % 100);
      if ($urandom % 60 == 0) en = ~en;
      if ($urandom % 90 == 0) therm = 1'b1;
      else if (therm && ($urandom % 3 == 0)) therm = 1'b0;
      period(r < 25 ? 2 : (r < 80 ? 1 : 0));
    end
    therm = 1'b0;
    en = 1'b1;
    periods(0, 2);
    finish_run();
  end

endmodule